// File: doc/BRIEF.md
# Four-Way True LRU Replacement Tracker

This block holds the replacement state of a set-associative cache with four ways per set, one state entry per set, picked through a set-index input. For every set it keeps an exact recency order of the ways: each way owns a rank, where rank 0 is the most recently used way and rank 3 is the least recently used one. The tag compare, the data array and the refill path are outside the block. It only sees their results: an access strobe, a hit flag, the way that hit, and the valid bits of the addressed set.

During a miss the block names the way to fill. An invalid way always wins over the least recently used way, and among several invalid ways the lowest-numbered one is chosen. The victim is computed combinationally from the stored order and the valid bits, so the cache controller can use it in the same cycle as the lookup. When the strobe is sampled at a clock edge, the target way moves to rank 0. The target is the hitting way on a hit and the victim on a miss. Every way that was more recent than the target moves down one rank, and the other ways keep their ranks.

Top module: `lru4_tracker`

## Requirements
- R1: After reset, way i of every set holds rank i (rank 0 = most recent). With all four valid bits set, victim_way is therefore 3 in every set.
- R2: If any bit of set_valid is 0, victim_way is the lowest index whose valid bit is 0.
- R3: If all four bits of set_valid are 1, victim_way is the way holding rank 3 (least recent) in the addressed set.
- R4: A strobed hit (acc_valid=1, acc_hit=1) moves acc_way to rank 0. Ways with a smaller old rank go down by one, and ways with a larger old rank are unchanged.
- R5: A strobed miss (acc_valid=1, acc_hit=0) moves the way shown on victim_way to rank 0 and shifts the other ways by the rule of R4.
- R6: A strobed hit on the way that already holds rank 0 leaves every rank unchanged.
- R7: With acc_valid=0 no rank changes. A strobed access changes only the set named by acc_set.
- R8: In every set the four ranks always form a permutation of 0..3.
- R9: victim_way follows acc_set and set_valid in the same cycle, with no clock edge in between.
- R10: In an empty set, fills of blocks A, C, B, D followed by a miss on E replace A. A later hit on B leaves C as the least recent way.
- R11: A cyclic stream over five distinct blocks that all map to one set never hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access strobe; when 1, the ranks of the addressed set are updated at the clock edge |
| acc_hit | input | 1 | 1 = hit on acc_way, 0 = miss filled into victim_way |
| acc_set | input | SET_W (4) | Index of the set being accessed |
| acc_way | input | WAY_W (2) | Way that hit; used only when acc_hit=1 |
| set_valid | input | WAYS (4) | Valid bit of each way of the addressed set |
| victim_way | output | WAY_W (2) | Way to fill on a miss, combinational |

## Verification
The bench keeps its own rank model and checks the victim on every access. Random valid masks test the invalid-first priority: a mask with one zero bit, a mask with several zero bits, and a full mask each reveal a different selection path. Random hits spread over every rank of the target way, including the one that is already most recent, and the LRU way seen afterwards shows whether the right neighbours were shifted. Directed block streams follow the tag level of a real cache. They include the five-block sequence with a later re-hit and the cyclic five-block thrash. Steps with the strobe low, and accesses to other sets, show that the untouched state stays put.

// File: rtl/lru4_pkg.sv
package lru4_pkg;
   // Kind of rank update requested in a cycle
   typedef enum logic [1:0] {
      UPD_NONE = 2'd0,
      UPD_HIT  = 2'd1,
      UPD_FILL = 2'd2
   } upd_kind_e;

   localparam int DEF_SETS = 16;
   localparam int DEF_WAYS = 4;
endpackage

// File: rtl/lru_rank_store.sv
module lru_rank_store #(
   parameter  int SETS  = 16,
   parameter  int WAYS  = 4,
   localparam int SET_W = $clog2(SETS),
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  wr_en,
   input  logic [SET_W-1:0]                      wr_set,
   input  logic [WAYS-1:0][WAY_W-1:0]            wr_rank,
   output logic [SETS-1:0][WAYS-1:0][WAY_W-1:0]  rank_q
);
   for (genvar s = 0; s < SETS; s++) begin : g_set
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int w = 0; w < WAYS; w++) rank_q[s][w] <= WAY_W'(w);
         end else if (wr_en && (wr_set == SET_W'(s))) begin
            rank_q[s] <= wr_rank;
         end
      end
   end
endmodule

// File: rtl/lru_victim_pick.sv
module lru_victim_pick #(
   parameter  int WAYS  = 4,
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic [WAYS-1:0][WAY_W-1:0] rank,
   input  logic [WAYS-1:0]            valid,
   output logic [WAY_W-1:0]           victim
);
   logic [WAY_W-1:0] inv_way;
   logic [WAY_W-1:0] lru_way;
   logic             any_inv;

   always_comb begin
      inv_way = '0;
      any_inv = 1'b0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (!valid[w]) begin
            inv_way = WAY_W'(w);
            any_inv = 1'b1;
         end
      end
   end

   always_comb begin
      lru_way = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (rank[w] == WAY_W'(WAYS - 1)) lru_way = WAY_W'(w);
      end
   end

   assign victim = any_inv ? inv_way : lru_way;
endmodule

// File: rtl/lru_rank_update.sv
module lru_rank_update #(
   parameter  int WAYS  = 4,
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic [WAYS-1:0][WAY_W-1:0] rank_in,
   input  logic [WAY_W-1:0]           target,
   output logic [WAYS-1:0][WAY_W-1:0] rank_out
);
   logic [WAY_W-1:0] tgt_rank;

   assign tgt_rank = rank_in[target];

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      always_comb begin
         if (target == WAY_W'(w))       rank_out[w] = '0;
         else if (rank_in[w] < tgt_rank) rank_out[w] = rank_in[w] + WAY_W'(1);
         else                            rank_out[w] = rank_in[w];
      end
   end
endmodule

// File: rtl/lru4_tracker.sv
module lru4_tracker
   import lru4_pkg::*;
#(
   parameter  int SETS  = DEF_SETS,
   parameter  int WAYS  = DEF_WAYS,
   localparam int SET_W = $clog2(SETS),
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc_valid,
   input  logic             acc_hit,
   input  logic [SET_W-1:0] acc_set,
   input  logic [WAY_W-1:0] acc_way,
   input  logic [WAYS-1:0]  set_valid,
   output logic [WAY_W-1:0] victim_way
);
   if (WAYS < 2 || (1 << WAY_W) != WAYS) begin : g_bad_ways
      $error("lru4_tracker: WAYS must be a power of two, at least 2");
   end
   if (SETS < 2 || (1 << SET_W) != SETS) begin : g_bad_sets
      $error("lru4_tracker: SETS must be a power of two, at least 2");
   end

   logic [SETS-1:0][WAYS-1:0][WAY_W-1:0] rank_all;
   logic [WAYS-1:0][WAY_W-1:0]           cur_rank;
   logic [WAYS-1:0][WAY_W-1:0]           nxt_rank;
   logic [WAY_W-1:0]                     target;
   upd_kind_e                            kind;

   assign cur_rank = rank_all[acc_set];

   always_comb begin
      if (!acc_valid)   kind = UPD_NONE;
      else if (acc_hit) kind = UPD_HIT;
      else              kind = UPD_FILL;
   end

   assign target = (kind == UPD_HIT) ? acc_way : victim_way;

   lru_victim_pick #(.WAYS(WAYS)) pick_i (
      .rank   (cur_rank),
      .valid  (set_valid),
      .victim (victim_way)
   );

   lru_rank_update #(.WAYS(WAYS)) upd_i (
      .rank_in  (cur_rank),
      .target   (target),
      .rank_out (nxt_rank)
   );

   lru_rank_store #(.SETS(SETS), .WAYS(WAYS)) store_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (kind != UPD_NONE),
      .wr_set  (acc_set),
      .wr_rank (nxt_rank),
      .rank_q  (rank_all)
   );
endmodule

// File: rtl/lru4_tracker_chk.sv
module lru4_tracker_chk #(
   parameter  int SETS  = 16,
   parameter  int WAYS  = 4,
   localparam int SET_W = $clog2(SETS),
   localparam int WAY_W = $clog2(WAYS)
) (
   input logic                                 clk,
   input logic                                 rst_n,
   input logic                                 acc_valid,
   input logic                                 acc_hit,
   input logic [SET_W-1:0]                     acc_set,
   input logic [WAY_W-1:0]                     acc_way,
   input logic [WAYS-1:0]                      set_valid,
   input logic [WAY_W-1:0]                     victim_way,
   input logic [SETS-1:0][WAYS-1:0][WAY_W-1:0] rank_all
);
   logic [WAYS-1:0] seen;
   logic [WAYS-1:0] below_mask;

   always_comb begin
      seen = '0;
      for (int w = 0; w < WAYS; w++) seen[rank_all[acc_set][w]] = 1'b1;
   end

   assign below_mask = (WAYS'(1) << victim_way) - WAYS'(1);

   // R2: lowest invalid way is the victim
   a_r2_lowest_invalid: assert property (@(posedge clk) disable iff (!rst_n)
      (set_valid != '1) |-> (!set_valid[victim_way] && ((~set_valid & below_mask) == '0)));

   // R3: all valid -> victim carries the LRU rank
   a_r3_lru_victim: assert property (@(posedge clk) disable iff (!rst_n)
      (set_valid == '1) |-> (rank_all[acc_set][victim_way] == WAY_W'(WAYS - 1)));

   // R4: hit way becomes most recent
   a_r4_hit_to_mru: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_hit) |=> (rank_all[$past(acc_set)][$past(acc_way)] == '0));

   // R5: filled way becomes most recent
   a_r5_fill_to_mru: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_hit) |=> (rank_all[$past(acc_set)][$past(victim_way)] == '0));

   // R6: hit on the MRU way changes nothing
   a_r6_mru_hit_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_hit && rank_all[acc_set][acc_way] == '0) |=> $stable(rank_all));

   // R7: no strobe, no change
   a_r7_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> $stable(rank_all));

   // R8: ranks of the addressed set form a permutation
   a_r8_permutation: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(seen) == WAYS);
endmodule

bind lru4_tracker lru4_tracker_chk #(.SETS(SETS), .WAYS(WAYS)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .acc_valid  (acc_valid),
   .acc_hit    (acc_hit),
   .acc_set    (acc_set),
   .acc_way    (acc_way),
   .set_valid  (set_valid),
   .victim_way (victim_way),
   .rank_all   (rank_all)
);

// File: tb/lru4_tracker_tb_top.sv
module lru4_tracker_tb_top;
   localparam int SETS  = 16;
   localparam int WAYS  = 4;
   localparam int SET_W = $clog2(SETS);
   localparam int WAY_W = $clog2(WAYS);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             acc_valid = 1'b0;
   logic             acc_hit = 1'b0;
   logic [SET_W-1:0] acc_set = '0;
   logic [WAY_W-1:0] acc_way = '0;
   logic [WAYS-1:0]  set_valid = '1;
   logic [WAY_W-1:0] victim_way;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   int mrank [SETS][WAYS];
   // tag-level model of one set for the block-stream tests
   int       ctag [WAYS];
   bit [3:0] cval;

   always #2.5 clk = ~clk;

   lru4_tracker #(.SETS(SETS), .WAYS(WAYS)) dut_i (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_hit(acc_hit),
      .acc_set(acc_set), .acc_way(acc_way), .set_valid(set_valid),
      .victim_way(victim_way)
   );

   function automatic int model_victim(int s, bit [3:0] v);
      for (int w = 0; w < WAYS; w++) if (!v[w]) return w;
      for (int w = 0; w < WAYS; w++) if (mrank[s][w] == WAYS - 1) return w;
      return 0;
   endfunction

   function automatic void model_touch(int s, int t);
      int tr = mrank[s][t];
      for (int w = 0; w < WAYS; w++) begin
         if (w == t) mrank[s][w] = 0;
         else if (mrank[s][w] < tr) mrank[s][w] = mrank[s][w] + 1;
      end
   endfunction

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // one clocked step: drive at negedge, check victim, let the edge pass
   task automatic step(string req, int s, bit strobe, bit hit, int way, bit [3:0] v);
      @(negedge clk);
      acc_set   = SET_W'(s);
      acc_valid = strobe;
      acc_hit   = hit;
      acc_way   = WAY_W'(way);
      set_valid = v;
      #1;
      check(req, int'(victim_way), model_victim(s, v));
      if (strobe) model_touch(s, hit ? way : model_victim(s, v));
      @(posedge clk);
      #1;
      acc_valid = 1'b0;
   endtask

   // probe the LRU way of a set with no update
   task automatic probe(string req, int s, int exp);
      @(negedge clk);
      acc_valid = 1'b0;
      acc_set   = SET_W'(s);
      set_valid = '1;
      #1;
      check(req, int'(victim_way), exp);
   endtask

   // tag-level access on set 5; returns 1 on hit
   task automatic blk(int tag, output bit was_hit, output int way);
      was_hit = 1'b0;
      way = 0;
      for (int w = 0; w < WAYS; w++)
         if (cval[w] && ctag[w] == tag) begin was_hit = 1'b1; way = w; end
      if (!was_hit) way = model_victim(5, cval);
      step(was_hit ? "R4" : "R5", 5, 1'b1, was_hit, way, cval);
      if (!was_hit) begin cval[way] = 1'b1; ctag[way] = tag; end
   endtask

   initial begin
      for (int s = 0; s < SETS; s++)
         for (int w = 0; w < WAYS; w++) mrank[s][w] = w;
      void'($urandom(32'h1EAF_5EED));
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset order in every set
      for (int s = 0; s < SETS; s++) probe("R1", s, 3);

      // R9: victim tracks set_valid within the cycle
      @(negedge clk);
      acc_set = SET_W'(2);
      set_valid = 4'b1011; #1 check("R9", int'(victim_way), 2);
      set_valid = 4'b0110; #1 check("R9", int'(victim_way), 0);
      // R2: several invalid ways -> lowest
      set_valid = 4'b0100; #1 check("R2", int'(victim_way), 0);
      set_valid = 4'b0001; #1 check("R2", int'(victim_way), 1);
      set_valid = 4'b0111; #1 check("R2", int'(victim_way), 3);

      // R7: strobe low with hit inputs set -> nothing moves
      step("R7", 3, 1'b0, 1'b1, 3, 4'b1111);
      probe("R7", 3, 3);
      // R6: hit on MRU way 0 keeps order
      step("R6", 4, 1'b1, 1'b1, 0, 4'b1111);
      probe("R6", 4, 3);
      // R4: hit on LRU way 3 -> way 2 becomes LRU
      step("R4", 4, 1'b1, 1'b1, 3, 4'b1111);
      probe("R4", 4, 2);
      // R7: other sets untouched by that access
      probe("R7", 3, 3);
      // R5: fill into LRU way 2 -> way 1 becomes LRU
      step("R5", 4, 1'b1, 1'b0, 0, 4'b1111);
      probe("R5", 4, 1);
      // R3: fill with an invalid way chooses it, then LRU shifts
      step("R3", 6, 1'b1, 1'b0, 0, 4'b1101);
      probe("R3", 6, 3);

      // R10: A C B D E then hit B
      begin
         bit h; int wy; int wa; int wb;
         cval = '0;
         blk(10, h, wa);  // A
         blk(12, h, wy);  // C
         blk(11, h, wb);  // B
         blk(13, h, wy);  // D
         blk(14, h, wy);  // E
         check("R10", wy, wa);
         blk(11, h, wy);  // B hits
         check("R10", int'(h), 1);
         probe("R10", 5, 1);   // C sits in way 1
      end

      // R11: cyclic five-block stream never hits
      begin
         bit h; int wy; int hits = 0;
         for (int r = 0; r < 6; r++)
            for (int b = 0; b < 5; b++) begin
               blk(100 + b, h, wy);
               if (h) hits++;
            end
         check("R11", hits, 0);
      end

      // random mix, R2 R3 R4 R5 R6 R8
      for (int i = 0; i < 3000; i++) begin
         int s = int'($urandom_range(SETS - 1));
         bit [3:0] v = ($urandom_range(1) != 0) ? 4'b1111 : 4'($urandom);
         bit st = $urandom_range(7) != 0;
         bit hh = $urandom_range(1) != 0;
         int wy = int'($urandom_range(WAYS - 1));
         step("R8", s, st, hh, wy, v);
      end
      for (int s = 0; s < SETS; s++) probe("R3", s, model_victim(s, 4'b1111));

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule